// File: doc/BRIEF.md
# Watchdog Timer with Interrupt and Reset Request

This block watches for a stalled processor. A free-running binary counter advances once every two system clocks. A two-bit period field chooses one of four counter stages as the detection point. If software does not write the clear code before that stage rolls over, the block raises a one-cycle interrupt. The counter then wraps and keeps running. In reset mode, the same rollover drives a reset request of fixed length instead of the interrupt. The counter is held at zero while that request is high.

Counting starts as soon as reset is released; no enable write is needed. Counting stops in the light idle and stop power modes. In the deep idle mode the counter runs only if a mode bit allows it. Counting carries on while the bus is granted to an external master.

Software uses one write port with two targets:
- The mode register (`reg_sel` = 0). Only data bits [4:0] are used:
  - bit 0: counter enable
  - bits 2:1: period select
  - bit 3: reset-request mode
  - bit 4: run in deep idle
- The command register (`reg_sel` = 1), which takes the clear code.

Top module: `wdog_ctl`

## Requirements
- R1: After `rst`, the mode register holds enable = 1, period = 0, reset mode = 0 and deep-idle run = 0, and both outputs are low. With no register write, the first interrupt occurs 2^(TAP_BASE+2) clock cycles after reset is released.
- R2: The counter advances once per two enabled clock cycles. Period select value p sets the overflow stage to bit TAP_BASE+TAP_STEP*p, which is bit 15, 17, 19 or 21 with the defaults. The first overflow comes 2^(stage+2) clock cycles after a clear.
- R3: `wd_irq` is high for exactly one cycle per overflow. The counter keeps running, so the next pulse follows 2^(stage+2) cycles later unless the counter is cleared.
- R4: Writing CLR_CODE (default 8'h4E) to the command register (`reg_sel` = 1) zeroes the counter and the prescaler. Any other value written there has no effect on the timing.
- R5: `pwr_mode` is encoded as 2'b00 run, 2'b01 light idle, 2'b10 deep idle and 2'b11 stop. In 2'b01 and 2'b11 the counter holds its value.
- R6: In deep idle (2'b10), the counter advances only when mode bit 4 is set. Otherwise it holds.
- R7: `bus_ack_n` low (bus released) does not change the counting (default KEEP_ON_BUSREL = 1).
- R8: With mode bit 3 set, an overflow raises `wd_rst_req` for exactly RST_LEN consecutive cycles (22 to 29, default 24) and produces no interrupt. The counter is held at zero during the pulse and restarts from zero when it ends.
- R9: With mode bit 0 clear, the counter holds its value and no overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 = mode register, 1 = command register |
| reg_wdata | input | 8 | Write data |
| pwr_mode | input | 2 | Power mode: 00 run, 01 light idle, 10 deep idle, 11 stop |
| bus_ack_n | input | 1 | Bus-release acknowledge, low while an external master owns the bus |
| wd_irq | output | 1 | Watchdog interrupt, one-cycle pulse |
| wd_rst_req | output | 1 | Internal reset request pulse |

## Verification
The assertions check on every cycle that:
- the interrupt is a single-cycle pulse;
- the counter stays frozen in the halting power modes and while disabled;
- a clear code leaves the counter at zero;
- every reset-request pulse is exactly RST_LEN cycles long and never overlaps the interrupt.

The detection latency for each period select, the wrong-code case, partial counts carried across idle periods and the deep-idle gating can only be shown by the bench scenarios. There, a behavioural model measures cycle counts between a clear and the next interrupt or reset request.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Power-mode input encoding
    typedef enum logic [1:0] {
        PM_RUN       = 2'b00,
        PM_IDLE_LITE = 2'b01,
        PM_IDLE_DEEP = 2'b10,
        PM_STOP      = 2'b11
    } pwr_mode_e;

    // Mode register, LSB first: enable, period, reset mode, deep-idle run
    typedef struct packed {
        logic       deep_run;
        logic       rst_en;
        logic [1:0] period;
        logic       enable;
    } wd_mode_t;

    localparam int MODE_W = $bits(wd_mode_t);

    localparam wd_mode_t MODE_RESET = '{
        deep_run: 1'b0,
        rst_en:   1'b0,
        period:   2'd0,
        enable:   1'b1
    };

    localparam int NUM_TAPS = 4;

    // Does the power mode let the counter advance?
    function automatic logic pm_counts(input wd_mode_t m, input logic [1:0] pm);
        logic ok;
        case (pwr_mode_e'(pm))
            PM_RUN:       ok = 1'b1;
            PM_IDLE_DEEP: ok = m.deep_run;
            default:      ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int         DATA_W   = 8,
    parameter logic [7:0] CLR_CODE = 8'h4E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output wd_mode_t          mode_q,
    output logic              clr_hit
);
    logic mode_wr;

    assign mode_wr = reg_wr & ~reg_sel;
    assign clr_hit = reg_wr & reg_sel & (reg_wdata == DATA_W'(CLR_CODE));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RESET;
        end else if (mode_wr) begin
            mode_q <= wd_mode_t'(reg_wdata[MODE_W-1:0]);
        end
    end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 22,
    parameter int TAP_BASE = 15,
    parameter int TAP_STEP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             hold_zero,
    input  logic [1:0]       period,
    output logic             ovf,
    output logic [CNT_W-1:0] cnt_q
);
    logic                phase_q;
    logic [NUM_TAPS-1:0] tap_full;

    // One "all ones below and at the tap" detector per selectable stage
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        localparam int TP = TAP_BASE + TAP_STEP * i;
        assign tap_full[i] = &cnt_q[TP:0];
    end

    always_ff @(posedge clk) begin
        if (rst || hold_zero) begin
            phase_q <= 1'b0;
            cnt_q   <= '0;
        end else if (run) begin
            phase_q <= ~phase_q;
            if (phase_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ovf = run & ~hold_zero & phase_q & tap_full[period];
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
    parameter int RST_LEN = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic active
);
    localparam int LW = $clog2(RST_LEN + 1);

    logic [LW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (trigger) begin
            left_q <= LW'(RST_LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active = (left_q != '0);
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
    import wdog_pkg::*;
#(
    parameter int         CNT_W          = 22,
    parameter int         TAP_BASE       = 15,
    parameter int         TAP_STEP       = 2,
    parameter int         RST_LEN        = 24,
    parameter logic [7:0] CLR_CODE       = 8'h4E,
    parameter bit         KEEP_ON_BUSREL = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    input  logic [1:0] pwr_mode,
    input  logic       bus_ack_n,
    output logic       wd_irq,
    output logic       wd_rst_req
);
    wd_mode_t         mode_q;
    logic             clr_hit;
    logic             bus_ok;
    logic             run;
    logic             hold_zero;
    logic             ovf;
    logic             rst_active;
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;

    wdog_regs #(
        .DATA_W   (8),
        .CLR_CODE (CLR_CODE)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .mode_q    (mode_q),
        .clr_hit   (clr_hit)
    );

    // Bus release only gates counting when the variant asks for it
    assign bus_ok    = bus_ack_n | KEEP_ON_BUSREL;
    assign run       = mode_q.enable & pm_counts(mode_q, pwr_mode) & bus_ok & ~rst_active;
    assign hold_zero = clr_hit | rst_active;

    wdog_count #(
        .CNT_W    (CNT_W),
        .TAP_BASE (TAP_BASE),
        .TAP_STEP (TAP_STEP)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .hold_zero (hold_zero),
        .period    (mode_q.period),
        .ovf       (ovf),
        .cnt_q     (cnt_q)
    );

    wdog_rstgen #(
        .RST_LEN (RST_LEN)
    ) u_rstgen (
        .clk     (clk),
        .rst     (rst),
        .trigger (ovf & mode_q.rst_en),
        .active  (rst_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= ovf & ~mode_q.rst_en;
        end
    end

    assign wd_irq     = irq_q;
    assign wd_rst_req = rst_active;
endmodule

// File: rtl/wdog_ctl_chk.sv
module wdog_ctl_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W   = 22,
    parameter int RST_LEN = 24
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       pwr_mode,
    input wd_mode_t         mode_q,
    input logic             clr_hit,
    input logic [CNT_W-1:0] cnt_q,
    input logic             wd_irq,
    input logic             wd_rst_req
);
    int unsigned hi_len;

    always_ff @(posedge clk) begin
        if (rst || !wd_rst_req) begin
            hi_len <= 0;
        end else begin
            hi_len <= hi_len + 1;
        end
    end

    initial begin
        assert_len_range_R8: assert (RST_LEN >= 22 && RST_LEN <= 29);
    end

    assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        wd_irq |=> !wd_irq);

    assert_halt_modes_R5: assert property (@(posedge clk) disable iff (rst)
        ((pwr_mode == PM_IDLE_LITE || pwr_mode == PM_STOP) && !clr_hit && !wd_rst_req)
        |=> $stable(cnt_q));

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
        clr_hit |=> (cnt_q == '0));

    assert_pulse_len_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_rst_req) |-> (hi_len == RST_LEN));

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        !(wd_irq && wd_rst_req));

    assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.enable && !clr_hit && !wd_rst_req) |=> $stable(cnt_q));
endmodule

bind wdog_ctl wdog_ctl_chk #(
    .CNT_W   (CNT_W),
    .RST_LEN (RST_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwr_mode   (pwr_mode),
    .mode_q     (mode_q),
    .clr_hit    (clr_hit),
    .cnt_q      (cnt_q),
    .wd_irq     (wd_irq),
    .wd_rst_req (wd_rst_req)
);

// File: tb/wdog_ctl_test.sv
module wdog_ctl_test;
    localparam int TB_BASE = 3;
    localparam int TB_STEP = 2;
    localparam int TB_LEN  = 24;
    localparam logic [7:0] CLR = 8'h4E;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [1:0] pwr_mode = 2'b00;
    logic       bus_ack_n = 1'b1;
    logic       wd_irq;
    logic       wd_rst_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit irq_seen = 1'b0;

    always #2 clk = ~clk;

    wdog_ctl #(
        .CNT_W    (10),
        .TAP_BASE (TB_BASE),
        .TAP_STEP (TB_STEP),
        .RST_LEN  (TB_LEN),
        .CLR_CODE (CLR)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .pwr_mode   (pwr_mode),
        .bus_ack_n  (bus_ack_n),
        .wd_irq     (wd_irq),
        .wd_rst_req (wd_rst_req)
    );

    // Behavioural model: elapsed half-ticks since the last clear
    int  m_en, m_per, m_rsten, m_deep, m_half, m_rleft;
    bit  m_irq;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 1; m_per = 0; m_rsten = 0; m_deep = 0;
            m_half = 0; m_rleft = 0; m_irq = 0;
        end else begin
            bit go, clr, ov;
            int span;
            go  = (m_en != 0) && m_rleft == 0 &&
                  (pwr_mode == 2'b00 || (pwr_mode == 2'b10 && m_deep != 0));
            clr = reg_wr && reg_sel && reg_wdata == CLR;
            span = 1 << (TB_BASE + TB_STEP * m_per + 2);
            ov  = go && !clr && ((m_half + 1) % span) == 0;
            m_irq = ov && m_rsten == 0;
            if (ov && m_rsten != 0) m_rleft = TB_LEN;
            else if (m_rleft > 0) begin
                m_rleft = m_rleft - 1;
                m_half = 0;
            end
            if (clr) m_half = 0;
            else if (go) m_half = (m_half + 1) % 2048;
            if (reg_wr && !reg_sel) begin
                m_en = reg_wdata[0]; m_per = reg_wdata[2:1];
                m_rsten = reg_wdata[3]; m_deep = reg_wdata[4];
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (wd_irq !== m_irq) begin
                errors++;
                $display("FAIL R3 cycle %0d wd_irq actual=%0b expected=%0b", cyc, wd_irq, m_irq);
            end
            checks++;
            if (wd_rst_req !== (m_rleft > 0)) begin
                errors++;
                $display("FAIL R8 cycle %0d wd_rst_req actual=%0b expected=%0b",
                         cyc, wd_rst_req, m_rleft > 0);
            end
            if (wd_irq) irq_seen = 1'b1;
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<=150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic meas_irq(output int n);
        n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (!wd_irq && n < 5000);
    endtask

    task automatic meas_rst(output int n);
        n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (!wd_rst_req && n < 5000);
    endtask

    initial begin
        int n;
        step(3);
        chk("R1 irq in reset", int'(wd_irq), 0);
        chk("R1 rst_req in reset", int'(wd_rst_req), 0);
        rst = 1'b0;
        meas_irq(n);
        chk("R1 first irq after reset", n, 32);

        // R3: single pulse, counter keeps running
        step(1);
        chk("R3 pulse width", int'(wd_irq), 0);
        meas_irq(n);
        chk("R3 second irq", n, 31);

        // R2: each period select
        for (int p = 0; p < 4; p++) begin
            wr(1'b0, 8'(1 + 2 * p));
            wr(1'b1, CLR);
            meas_irq(n);
            chk("R2 period latency", n, 1 << (5 + 2 * p));
        end
        wr(1'b0, 8'h01);

        // R4: wrong code ignored, correct code restarts
        wr(1'b1, CLR);
        step(20);
        wr(1'b1, 8'h4D);
        meas_irq(n);
        chk("R4 wrong code ignored", n, 11);
        wr(1'b1, CLR);
        irq_seen = 1'b0;
        for (int k = 0; k < 5; k++) begin
            step(20);
            wr(1'b1, CLR);
        end
        chk("R4 periodic clears prevent irq", int'(irq_seen), 0);

        // R5: light idle and stop hold the count
        for (int k = 0; k < 2; k++) begin
            wr(1'b1, CLR);
            step(10);
            pwr_mode = (k == 0) ? 2'b01 : 2'b11;
            irq_seen = 1'b0;
            step(100);
            chk("R5 halted no irq", int'(irq_seen), 0);
            pwr_mode = 2'b00;
            meas_irq(n);
            chk("R5 resume remaining", n, 22);
        end

        // R6: deep idle gated by mode bit 4
        wr(1'b1, CLR);
        pwr_mode = 2'b10;
        irq_seen = 1'b0;
        step(100);
        chk("R6 deep idle held", int'(irq_seen), 0);
        wr(1'b0, 8'h11);
        meas_irq(n);
        chk("R6 deep idle run", n, 32);
        pwr_mode = 2'b00;
        wr(1'b0, 8'h01);

        // R7: bus release does not stop counting
        bus_ack_n = 1'b0;
        wr(1'b1, CLR);
        meas_irq(n);
        chk("R7 bus released latency", n, 32);
        bus_ack_n = 1'b1;

        // R9: disable holds the count
        wr(1'b0, 8'h00);
        wr(1'b1, CLR);
        irq_seen = 1'b0;
        step(200);
        chk("R9 disabled no irq", int'(irq_seen), 0);
        wr(1'b0, 8'h01);
        meas_irq(n);
        chk("R9 re-enabled latency", n, 32);

        // R8: reset-request mode
        wr(1'b0, 8'h09);
        wr(1'b1, CLR);
        irq_seen = 1'b0;
        meas_rst(n);
        chk("R8 reset request latency", n, 32);
        n = 0;
        while (wd_rst_req && n < 100) begin
            @(posedge clk); n++; @(negedge clk);
        end
        chk("R8 reset pulse length", n, TB_LEN);
        meas_rst(n);
        chk("R8 restart after pulse", n, 32);
        step(30);
        chk("R8 no irq in reset mode", int'(irq_seen), 0);
        wr(1'b0, 8'h01);

        step(5);
        finish_run();
    end
endmodule